// File: doc/BRIEF.md
# Quadrature and Direction-Count Position Decoder

This block turns the two signal lines of an incremental position encoder into a signed position count. In quadrature mode, the two lines carry square waves 90 degrees apart. Every rising and falling edge of either line is one count step, which gives four steps per input cycle. The phase order of the two lines sets the counting direction. In direction-count mode, the first line is a step clock and the second is a direction level.

Both lines pass through synchronizer flops before decoding, so they may come from pins that are not tied to the block clock. A swap control exchanges the roles of the two lines, which reverses the counting sense of an encoder that was mounted backwards.

A sticky phase-error flag records any sample in which both lines changed at once, because that transition cannot be decoded. A software-style write-one-to-clear pulse clears the flag. An enable gates a one-cycle interrupt pulse that goes with each error.

Top module: `qdec_position_top`

## Requirements
- R1: In quadrature mode (modeDirCount=0), each single change of either line is one count step. On each step, countPulse is high for exactly one cycle, in the same cycle that position shows the new value.
- R2: In quadrature mode, with state {A,B} and A in bit 1, the order 00→10→11→01→00 adds 1 per step and the reverse order subtracts 1. On a step, dirUp becomes 1 for up and 0 for down, and it holds that value between steps.
- R3: In quadrature mode, if both lines change in the same sample, phaseErrFlag is set. Position and dirUp stay unchanged and there is no countPulse.
- R4: With swapInputs=1, line B takes the A role and line A takes the B role, so the same input waveforms count in the opposite direction.
- R5: In direction-count mode (modeDirCount=1), only a rising edge of the (possibly swapped) A role counts: +1 if the B role is 1, −1 if it is 0. Falling A edges and B changes do nothing, and no phase error is raised in this mode.
- R6: phaseErrFlag stays set until an errClear pulse. If errClear and a new error fall in the same cycle, the flag stays set.
- R7: irqPulse is a one-cycle pulse, raised in the cycle the flag is set by an error, only when irqEnable=1. With irqEnable=0, an error gives no pulse.
- R8: position is 32 bits and wraps: one down step from 0 gives 0xFFFFFFFF, and one up step from there gives 0.
- R9: A posClear pulse sets position to 0 on the next clock edge. A step that falls in the same cycle is dropped and gives no countPulse.
- R10: After reset: position=0, phaseErrFlag=0, dirUp=1, and countPulse and irqPulse are low.
- R11: A line change driven between clock edges shows on the outputs after the third following rising edge. Two edges are for synchronization and one is for the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset |
| encA | input | 1 | Encoder line A (asynchronous) |
| encB | input | 1 | Encoder line B (asynchronous) |
| modeDirCount | input | 1 | 0: quadrature, 1: clock plus direction |
| swapInputs | input | 1 | Exchange the roles of A and B |
| posClear | input | 1 | Synchronous clear of position |
| errClear | input | 1 | Write-one-to-clear for the error flag |
| irqEnable | input | 1 | Enables irqPulse on a phase error |
| position | output | 32 | Signed position count, wrapping |
| countPulse | output | 1 | One-cycle pulse per applied step |
| dirUp | output | 1 | Direction of the last step (1 = up) |
| phaseErrFlag | output | 1 | Sticky phase-error flag |
| irqPulse | output | 1 | One-cycle phase-error interrupt pulse |

## Verification
The step-size and direction properties assume that modeDirCount and swapInputs do not change while a line change is still in the synchronizers. They also assume that both controls change only while A and B are at equal levels, so the effective {A,B} state cannot jump. The stimulus waits for every line change to settle before it touches any control. It toggles mode and swap only while the two lines match, and it keeps posClear pulses away from steps in flight. The irq property also assumes irqEnable is steady across the decode cycle, which the settle gap guarantees.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic step;      // apply one count step
    logic stepUp;    // direction of that step
    logic phaseErr;  // undecodable transition seen
  } qdec_strobe_t;
endpackage

// File: rtl/qdec_ctrl.sv
module qdec_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  encA,
  input  logic                  encB,
  input  logic                  modeDirCount,
  input  logic                  swapInputs,
  output qdec_pkg::qdec_strobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncA;
  logic [LAST:0] syncB;
  logic [1:0]    abNow;
  logic [1:0]    abPrev;
  logic [1:0]    delta;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= encA;
          syncB <= encB;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= {syncA[LAST-1:0], encA};
          syncB <= {syncB[LAST-1:0], encB};
        end
      end
    end
  endgenerate

  // Role exchange ahead of the decoder
  assign abNow = swapInputs ? {syncB[LAST], syncA[LAST]}
                            : {syncA[LAST], syncB[LAST]};
  assign delta = abPrev ^ abNow;

  always_ff @(posedge clk) begin
    if (!rstN) abPrev <= 2'b00;
    else       abPrev <= abNow;
  end

  always_comb begin
    strobe = '0;
    if (modeDirCount) begin
      strobe.step   = !abPrev[1] && abNow[1];
      strobe.stepUp = abNow[0];
    end else begin
      unique case (delta)
        2'b00: ;
        2'b11: strobe.phaseErr = 1'b1;
        default: begin
          strobe.step = 1'b1;
          unique case ({abPrev, abNow})
            4'b0010, 4'b1011, 4'b1101, 4'b0100: strobe.stepUp = 1'b1;
            default:                            strobe.stepUp = 1'b0;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath #(
  parameter int POS_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  qdec_pkg::qdec_strobe_t strobe,
  input  logic                   posClear,
  input  logic                   errClear,
  input  logic                   irqEnable,
  output logic [POS_W-1:0]       position,
  output logic                   countPulse,
  output logic                   dirUp,
  output logic                   phaseErrFlag,
  output logic                   irqPulse
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      position     <= '0;
      countPulse   <= 1'b0;
      dirUp        <= 1'b1;
      phaseErrFlag <= 1'b0;
      irqPulse     <= 1'b0;
    end else begin
      countPulse <= strobe.step && !posClear;
      if (posClear)
        position <= '0;
      else if (strobe.step)
        position <= strobe.stepUp ? position + ONE : position - ONE;
      if (strobe.step && !posClear)
        dirUp <= strobe.stepUp;
      phaseErrFlag <= strobe.phaseErr || (phaseErrFlag && !errClear);
      irqPulse     <= strobe.phaseErr && irqEnable;
    end
  end
endmodule

// File: rtl/qdec_position_top.sv
module qdec_position_top #(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             modeDirCount,
  input  logic             swapInputs,
  input  logic             posClear,
  input  logic             errClear,
  input  logic             irqEnable,
  output logic [POS_W-1:0] position,
  output logic             countPulse,
  output logic             dirUp,
  output logic             phaseErrFlag,
  output logic             irqPulse
);
  qdec_pkg::qdec_strobe_t strobe;

  qdec_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB),
    .modeDirCount(modeDirCount), .swapInputs(swapInputs), .strobe(strobe)
  );

  qdec_datapath #(.POS_W(POS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .posClear(posClear),
    .errClear(errClear), .irqEnable(irqEnable), .position(position),
    .countPulse(countPulse), .dirUp(dirUp), .phaseErrFlag(phaseErrFlag),
    .irqPulse(irqPulse)
  );
endmodule

// File: rtl/qdec_position_checker.sv
module qdec_position_checker #(
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             posClear,
  input logic             errClear,
  input logic             irqEnable,
  input logic [POS_W-1:0] position,
  input logic             countPulse,
  input logic             dirUp,
  input logic             phaseErrFlag,
  input logic             irqPulse
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  assert_step_size_R1: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> (position == $past(position) + ONE) || (position == $past(position) - ONE));

  assert_dir_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> (dirUp == (position == $past(position) + ONE)));

  assert_hold_no_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!countPulse && !$past(posClear)) |-> (position == $past(position)));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phaseErrFlag) && !$past(errClear)) |-> phaseErrFlag);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (phaseErrFlag && $past(irqEnable)));

  assert_irq_no_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(irqPulse && countPulse));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(posClear) |-> (position == '0 && !countPulse));
endmodule

bind qdec_position_top qdec_position_checker #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rstN(rstN), .posClear(posClear), .errClear(errClear),
  .irqEnable(irqEnable), .position(position), .countPulse(countPulse),
  .dirUp(dirUp), .phaseErrFlag(phaseErrFlag), .irqPulse(irqPulse)
);

// File: tb/qdec_position_top_tb_top.sv
`timescale 1ns/1ps
module qdec_position_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encA = 1'b0, encB = 1'b0;
  logic modeDirCount = 1'b0, swapInputs = 1'b0;
  logic posClear = 1'b0, errClear = 1'b0, irqEnable = 1'b0;
  logic [31:0] position;
  logic countPulse, dirUp, phaseErrFlag, irqPulse;

  int checks = 0, fails = 0;
  int pulseCnt = 0, irqCnt = 0;
  logic [31:0] expPos = '0;
  logic expDir = 1'b1, expFlag = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qdec_position_top dut_i (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB),
    .modeDirCount(modeDirCount), .swapInputs(swapInputs),
    .posClear(posClear), .errClear(errClear), .irqEnable(irqEnable),
    .position(position), .countPulse(countPulse), .dirUp(dirUp),
    .phaseErrFlag(phaseErrFlag), .irqPulse(irqPulse)
  );

  always @(negedge clk) if (rstN) begin
    if (countPulse) pulseCnt++;
    if (irqPulse)   irqCnt++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] effOf(logic a, logic b, logic sw);
    return sw ? {b, a} : {a, b};
  endfunction

  // 0 none, 1 up, -1 down, 2 phase error
  function automatic int modelStep(logic [1:0] p, logic [1:0] c, logic dm);
    if (dm) begin
      if (!p[1] && c[1]) return c[0] ? 1 : -1;
      return 0;
    end
    if (p == c) return 0;
    if ((p ^ c) == 2'b11) return 2;
    if ((p == 2'b00 && c == 2'b10) || (p == 2'b10 && c == 2'b11) ||
        (p == 2'b11 && c == 2'b01) || (p == 2'b01 && c == 2'b00)) return 1;
    return -1;
  endfunction

  task automatic driveLines(logic a, logic b, string tag);
    int k, p0, i0;
    logic expIrq;
    k  = modelStep(effOf(encA, encB, swapInputs), effOf(a, b, swapInputs), modeDirCount);
    p0 = pulseCnt; i0 = irqCnt;
    expIrq = (k == 2) && irqEnable;
    @(negedge clk); encA = a; encB = b;
    repeat (5) @(negedge clk);
    if (k == 1)       begin expPos = expPos + 1; expDir = 1'b1; end
    else if (k == -1) begin expPos = expPos - 1; expDir = 1'b0; end
    else if (k == 2)  expFlag = 1'b1;
    chk({tag, " position"}, position, expPos);
    chk({tag, " dirUp"}, {31'b0, dirUp}, {31'b0, expDir});
    chk({tag, " flag"}, {31'b0, phaseErrFlag}, {31'b0, expFlag});
    chk({tag, " pulses"}, pulseCnt - p0, (k == 1 || k == -1) ? 1 : 0);
    chk({tag, " irq"}, irqCnt - i0, {31'b0, expIrq});
  endtask

  task automatic clearErr(string tag);
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
    expFlag = 1'b0;
    @(negedge clk);
    chk(tag, {31'b0, phaseErrFlag}, 32'd0);
  endtask

  task automatic clearPos(string tag);
    int p0;
    p0 = pulseCnt;
    @(negedge clk); posClear = 1'b1;
    @(negedge clk); posClear = 1'b0;
    expPos = '0;
    @(negedge clk);
    chk({tag, " position"}, position, 32'd0);
    chk({tag, " pulses"}, pulseCnt - p0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 position", position, 32'd0);
    chk("R10 flag", {31'b0, phaseErrFlag}, 32'd0);
    chk("R10 dirUp", {31'b0, dirUp}, 32'd1);
    chk("R10 pulses", {30'b0, countPulse, irqPulse}, 32'd0);

    // R1 R2: full up cycle then down past zero (R8 wrap)
    driveLines(1, 0, "R1 up 00-10");
    driveLines(1, 1, "R2 up 10-11");
    driveLines(0, 1, "R2 up 11-01");
    driveLines(0, 0, "R1 up 01-00");
    chk("R2 four counts", position, 32'd4);
    clearPos("R9 clear");
    driveLines(0, 1, "R8 down from zero");
    chk("R8 wrap low", position, 32'hFFFF_FFFF);
    driveLines(0, 0, "R8 up to zero");
    chk("R8 wrap high", position, 32'd0);

    // R11 latency of a single change
    begin
      int p0;
      p0 = pulseCnt;
      @(negedge clk); encA = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R11 no pulse after two edges", {31'b0, countPulse}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R11 pulse after third edge", {31'b0, countPulse}, 32'd1);
      chk("R11 position after third edge", position, 32'd1);
      @(negedge clk);
      chk("R1 pulse one cycle", {31'b0, countPulse}, 32'd0);
      expPos = 32'd1; expDir = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R3 R7: error with irq disabled, then enabled
    driveLines(0, 1, "R3 both change, irq off R7");
    clearErr("R6 clear");
    irqEnable = 1'b1;
    driveLines(1, 0, "R3 both change, irq on R7");
    // R6: clear collides with a new error
    begin
      @(negedge clk); encA = 1'b0; encB = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk); errClear = 1'b1;
      @(negedge clk); errClear = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 set wins over clear", {31'b0, phaseErrFlag}, 32'd1);
      chk("R3 position held", position, expPos);
    end
    clearErr("R6 clear after collision");
    irqEnable = 1'b0;
    driveLines(0, 0, "R1 return to 00");

    // R4 swap: same raw waveforms count down
    swapInputs = 1'b1;
    begin
      logic [31:0] base;
      base = expPos;
      driveLines(1, 0, "R4 swapped");
      driveLines(1, 1, "R4 swapped");
      driveLines(0, 1, "R4 swapped");
      driveLines(0, 0, "R4 swapped");
      chk("R4 swap reverses", position, base - 32'd4);
    end
    swapInputs = 1'b0;

    // R5 direction-count mode
    modeDirCount = 1'b1;
    driveLines(0, 1, "R5 B change only");
    driveLines(1, 1, "R5 rise B high");
    driveLines(0, 1, "R5 A falls");
    driveLines(0, 0, "R5 B falls");
    driveLines(1, 0, "R5 rise B low");
    driveLines(0, 1, "R5 both change no error");
    driveLines(0, 0, "R5 settle");
    modeDirCount = 1'b0;

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 70) begin
        if ($urandom_range(0, 1)) driveLines(~encA, encB, "R1 R2 R5 random step");
        else                      driveLines(encA, ~encB, "R1 R2 R5 random step");
      end else if (r < 78) driveLines(~encA, ~encB, "R3 R5 random double change");
      else if (r < 86) begin
        if (encA == encB) begin
          if ($urandom_range(0, 1)) swapInputs = ~swapInputs;
          else                      modeDirCount = ~modeDirCount;
        end
      end else if (r < 92) clearErr("R6 random clear");
      else if (r < 95) clearPos("R9 random clear");
      else irqEnable = ~irqEnable;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule